// File: doc/BRIEF.md
# Four-channel PCM transmit serializer

This block puts four channels of 8-bit companded PCM code words onto serial data pins. It runs on the rising edge of the bit clock. A transmit sync pulse that is phase-aligned to that clock marks the start of each frame. When the block sees a rising edge on the sync line, it captures the four sample bytes, the multiplex mode and the coding law. It then shifts the code words out most significant bit first, one bit per bit-clock edge. In parallel mode each channel has its own pin. In serial mode the four channels follow one another in four 8-bit slots on the first pin.

Each pin has a data output and an output enable, which together model an open-drain pin that floats outside its own 8-bit window. When the block floats a pin it drives its data output low. With the A-law setting, every other bit of each code word is inverted on the way out. With the mu-law setting, code words pass through unchanged. If the sync line stops toggling, whether it is stuck high or stuck low, the block counts bit clocks. Once a programmable limit is reached it enters power saving, with every pin floating. The next sync rising edge wakes the block and starts a new frame.

The controller has three states. SAVE is the power-saving state and is entered at reset. IDLE waits for sync with all pins floating. SHIFT drives a frame. Transitions:
- Any state goes to SHIFT on a sync edge. From SHIFT this is a restart.
- SHIFT goes to IDLE after the last bit of the frame.
- Any state goes to SAVE when the idle limit expires and there is no sync edge in the same cycle.

Top module: `pcm_tx_serializer`

## Requirements
- R1: After reset the block is in SAVE: `pwr_save_o` is 1, all `dout_oe_o` bits are 0 and all `dout_o` bits are 0.
- R2: A sync edge is a bit-clock rising edge at which `sync_i` is 1 and was 0 at the previous edge. The MSB of the first slot is driven in the cycle that immediately follows that edge. After that, one further bit follows per bit-clock edge, MSB first.
- R3: In parallel mode (`serial_mode_i`=0), channel c (bits [8c+7:8c] of `sample_i`) is driven on pin c for 8 cycles. All four enables are high together for exactly those 8 cycles.
- R4: In serial mode (`serial_mode_i`=1), pin 0 carries channel 0, 1, 2, 3 in four consecutive 8-bit slots, 32 cycles in all. The enables of pins 1 to 3 stay 0.
- R5: A pin's enable is 0 outside its own bit window. While the enable is 0, the data output is 0.
- R6: With `alaw_i`=1, each code word is XORed with 8'h55 (bit positions 6, 4, 2 and 0, the even bits counted from 1 at the MSB). With `alaw_i`=0 it is sent unchanged. For example, 8'hFF is sent as 8'hAA and 8'h80 is sent as 8'hD5.
- R7: The samples, the mode and the law are captured at the sync edge. Changes to them during a frame have no effect on that frame.
- R8: A sync edge that arrives during a frame abandons the current frame and starts a new one, following R2.
- R9: After IDLE_LIMIT consecutive bit-clock edges with no sync edge, counted from the last sync edge, the block enters SAVE and all enables go to 0. This applies whether the sync line is held at 1 or at 0.
- R10: The first sync edge seen in SAVE clears `pwr_save_o` in the next cycle and starts a frame, following R2.
- R11: Frames come out correctly for any spacing of sync edges that is at least the frame length and below IDLE_LIMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Transmit frame sync, phase-aligned to bclk_i |
| sample_i | input | NCH*W | Sample bytes, channel c at bits [c*W +: W] |
| serial_mode_i | input | 1 | 1: four-slot multiplex on pin 0, 0: one pin per channel |
| alaw_i | input | 1 | 1: invert even bits (A-law), 0: pass through (mu-law) |
| dout_o | output | NCH | Serial data per pin, 0 while not enabled |
| dout_oe_o | output | NCH | Output enable per pin (0 models high impedance) |
| pwr_save_o | output | 1 | 1 while in the power-saving state |

## Verification
The bench builds the block with four channels of 8 bits and an IDLE_LIMIT of 64 instead of 1024. With that limit, the entry into power saving, for both a line held low and a line held high, and the wake-up that follows, can be reached within a few hundred cycles. The sweep covers every combination of mode and law with four sample sets, including the reference full-scale and zero codes, at several frame spacings. It checks every output pin in every cycle of every frame. It also includes a restart in the middle of a frame.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    typedef enum logic [1:0] {
        ST_SAVE  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_SHIFT = 2'd2
    } tx_state_e;

    // Bits numbered 1 at the MSB; even-numbered bits set in the mask.
    function automatic logic [31:0] even_bit_mask(input int width);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < width; i++) begin
            if (((width - i) % 2) == 0) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pcm_tx_sync_mon.sv
module pcm_tx_sync_mon #(
    parameter int IDLE_LIMIT = 1024
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sync_i,
    output logic edge_o,
    output logic expire_o
);
    localparam int CW = $clog2(IDLE_LIMIT + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(IDLE_LIMIT - 1);

    logic          sync_q;
    logic [CW-1:0] idle_cnt_q;

    assign edge_o   = sync_i & ~sync_q;
    assign expire_o = ~edge_o & (idle_cnt_q == CNT_TOP);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q     <= 1'b1;
            idle_cnt_q <= CNT_TOP;
        end else begin
            sync_q <= sync_i;
            if (edge_o) begin
                idle_cnt_q <= '0;
            end else if (idle_cnt_q != CNT_TOP) begin
                idle_cnt_q <= idle_cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcm_tx_frame_ctl.sv
module pcm_tx_frame_ctl
    import pcm_tx_pkg::*;
#(
    parameter int NCH = 4,
    parameter int W   = 8
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      edge_i,
    input  logic      expire_i,
    input  logic      serial_i,
    output tx_state_e state_o,
    output logic      serial_q_o,
    output logic      shift_o
);
    localparam int FRAME_BITS = NCH * W;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_SER = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_PAR = CNT_W'(W - 1);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             serial_q;
    logic             last_bit;

    assign last_bit = (cnt_q == (serial_q ? LAST_SER : LAST_PAR));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q  <= ST_SAVE;
            cnt_q    <= '0;
            serial_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (edge_i) serial_q <= serial_i;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        if (edge_i) begin
            state_d = ST_SHIFT;
        end else if (expire_i) begin
            state_d = ST_SAVE;
        end else begin
            unique case (state_q)
                ST_SAVE:  state_d = ST_SAVE;
                ST_IDLE:  state_d = ST_IDLE;
                ST_SHIFT: begin
                    if (last_bit) begin
                        state_d = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default:  state_d = ST_SAVE;
            endcase
        end
    end

    always_comb begin
        state_o    = state_q;
        serial_q_o = serial_q;
        shift_o    = (state_q == ST_SHIFT) && !edge_i;
    end
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         shift_i,
    input  logic         ser_i,
    output logic         msb_o
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sr_q <= '0;
        end else if (load_i) begin
            sr_q <= load_val_i;
        end else if (shift_i) begin
            sr_q <= {sr_q[W-2:0], ser_i};
        end
    end

    assign msb_o = sr_q[W-1];
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer
    import pcm_tx_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int W          = 8,
    parameter int IDLE_LIMIT = 1024
) (
    input  logic             bclk_i,
    input  logic             rst_ni,
    input  logic             sync_i,
    input  logic [NCH*W-1:0] sample_i,
    input  logic             serial_mode_i,
    input  logic             alaw_i,
    output logic [NCH-1:0]   dout_o,
    output logic [NCH-1:0]   dout_oe_o,
    output logic             pwr_save_o
);
    localparam logic [31:0]  MASK32   = even_bit_mask(W);
    localparam logic [W-1:0] LAW_MASK = MASK32[W-1:0];

    logic      sync_edge;
    logic      idle_expire;
    tx_state_e state;
    logic      serial_q;
    logic      shift_en;
    logic [NCH-1:0] lane_msb;

    pcm_tx_sync_mon #(.IDLE_LIMIT(IDLE_LIMIT)) u_mon (
        .clk_i   (bclk_i),
        .rst_ni  (rst_ni),
        .sync_i  (sync_i),
        .edge_o  (sync_edge),
        .expire_o(idle_expire)
    );

    pcm_tx_frame_ctl #(.NCH(NCH), .W(W)) u_ctl (
        .clk_i     (bclk_i),
        .rst_ni    (rst_ni),
        .edge_i    (sync_edge),
        .expire_i  (idle_expire),
        .serial_i  (serial_mode_i),
        .state_o   (state),
        .serial_q_o(serial_q),
        .shift_o   (shift_en)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        logic         chain_in;
        logic [W-1:0] coded;

        assign coded = sample_i[c*W +: W] ^ (alaw_i ? LAW_MASK : '0);

        if (c == NCH - 1) begin : g_tail
            assign chain_in = 1'b0;
        end else begin : g_link
            assign chain_in = serial_q & lane_msb[c+1];
        end

        pcm_tx_lane #(.W(W)) u_lane (
            .clk_i     (bclk_i),
            .rst_ni    (rst_ni),
            .load_i    (sync_edge),
            .load_val_i(coded),
            .shift_i   (shift_en),
            .ser_i     (chain_in),
            .msb_o     (lane_msb[c])
        );

        always_comb begin
            if (c == 0) begin
                dout_oe_o[c] = (state == ST_SHIFT);
            end else begin
                dout_oe_o[c] = (state == ST_SHIFT) && !serial_q;
            end
            dout_o[c] = dout_oe_o[c] & lane_msb[c];
        end
    end

    assign pwr_save_o = (state == ST_SAVE);
endmodule

// File: rtl/pcm_tx_serializer_chk.sv
module pcm_tx_serializer_chk #(
    parameter int NCH = 4,
    parameter int W   = 8
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           sync_edge,
    input logic           serial_q,
    input logic           pwr_save_o,
    input logic [NCH-1:0] dout_o,
    input logic [NCH-1:0] dout_oe_o
);
    localparam int RW = $clog2(NCH * W + 2);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) run_q <= '0;
        else if (sync_edge) run_q <= '0;
        else if (dout_oe_o[0]) run_q <= run_q + 1'b1;
        else run_q <= '0;
    end

    AST_SAVE_ALL_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_save_o |-> (dout_oe_o == '0)); // R9
    AST_DATA_LOW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dout_o & ~dout_oe_o) == '0); // R5
    AST_SERIAL_ONE_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        serial_q |-> (dout_oe_o[NCH-1:1] == '0)); // R4
    AST_PARALLEL_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !serial_q |-> (dout_oe_o == '0 || dout_oe_o == '1)); // R3
    AST_WAKE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_edge |=> (!pwr_save_o && dout_oe_o[0])); // R10
    AST_WINDOW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q <= RW'(NCH * W)); // R2
endmodule

bind pcm_tx_serializer pcm_tx_serializer_chk #(.NCH(NCH), .W(W)) u_chk (
    .clk_i     (bclk_i),
    .rst_ni    (rst_ni),
    .sync_edge (sync_edge),
    .serial_q  (serial_q),
    .pwr_save_o(pwr_save_o),
    .dout_o    (dout_o),
    .dout_oe_o (dout_oe_o)
);

// File: tb/pcm_tx_serializer_bench.sv
module pcm_tx_serializer_bench;
    localparam int NCH = 4;
    localparam int W   = 8;
    localparam int LIM = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync = 1'b0;
    logic [31:0] smp = '0;
    logic        ser = 1'b0;
    logic        alw = 1'b0;
    logic [3:0]  dout, oe;
    logic        pws;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pcm_tx_serializer #(.NCH(NCH), .W(W), .IDLE_LIMIT(LIM)) u_pcm_tx_serializer (
        .bclk_i(clk), .rst_ni(rst_n), .sync_i(sync), .sample_i(smp),
        .serial_mode_i(ser), .alaw_i(alw), .dout_o(dout), .dout_oe_o(oe),
        .pwr_save_o(pws)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at a falling edge. Period = bit clocks between sync edges.
    task automatic run_frame(input bit f_ser, input bit f_alw, input logic [31:0] f_smp,
                             input int period, input bit hold, input string tag);
        logic [7:0] b [4];
        logic [3:0] eoe, ed;
        bit pw;
        if (sync) begin
            sync = 1'b0;
            @(negedge clk);
        end
        sync = 1'b1; ser = f_ser; alw = f_alw; smp = f_smp;
        for (int c = 0; c < 4; c++) b[c] = f_smp[c*8 +: 8] ^ (f_alw ? 8'h55 : 8'h00);
        @(negedge clk);
        for (int k = 0; k < period; k++) begin
            pw = (k >= LIM); eoe = '0; ed = '0;
            if (!pw) begin
                if (f_ser) begin
                    if (k < 32) begin eoe = 4'b0001; ed[0] = b[k/8][7 - k%8]; end
                end else if (k < 8) begin
                    eoe = 4'hF;
                    for (int c = 0; c < 4; c++) ed[c] = b[c][7 - k];
                end
            end
            check({tag, " enable"}, 32'(oe), 32'(eoe));
            check({tag, " data"}, 32'(dout), 32'(ed));
            check({tag, " pwr_save"}, 32'(pws), 32'(pw));
            if (k == 0) begin
                if (!hold) sync = 1'b0;
                smp = ~f_smp; ser = ~f_ser; alw = ~f_alw; // R7: ignored mid-frame
            end
            if (k < period - 1) @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] pat;
        string base;
        repeat (3) @(negedge clk);
        check("R1 pwr_save", 32'(pws), 32'd1);
        check("R1 enable", 32'(oe), 32'd0);
        check("R1 data", 32'(dout), 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 R9 pwr_save after release", 32'(pws), 32'd1);
        check("R1 enable after release", 32'(oe), 32'd0);

        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 2; a++) begin
                for (int p = 0; p < 4; p++) begin
                    if (p == 0) pat = {8'h00, 8'h7F, 8'hFF, 8'h80};
                    else begin
                        pat = '0;
                        for (int c = 0; c < 4; c++)
                            pat[c*8 +: 8] = 8'((p * 37 + c * 53 + s * 11 + a * 29) % 256);
                    end
                    base = {"R2 R5 R7 R11 ", (s != 0) ? "R4" : "R3", (a != 0) ? " R6" : ""};
                    run_frame(s != 0, a != 0, pat, 34 + p * 8, 1'b0, base);
                end
            end
        end

        run_frame(1'b1, 1'b0, 32'h1234_5678, 12, 1'b0, "R8 interrupted");
        run_frame(1'b1, 1'b1, 32'h9ABC_DEF0, 40, 1'b0, "R8 restarted");
        run_frame(1'b0, 1'b0, 32'hA5C3_3C5A, LIM + 6, 1'b0, "R9 stuck low");
        run_frame(1'b0, 1'b1, 32'h0F1E_2D3C, 40, 1'b0, "R10 wake parallel");
        run_frame(1'b1, 1'b0, 32'h8001_7FFE, LIM + 6, 1'b1, "R9 stuck high");
        run_frame(1'b1, 1'b1, 32'h55AA_C396, 40, 1'b0, "R10 wake serial");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule